// File: doc/BRIEF.md
# Weighted Time-Sample Trigger Sum

This block turns a stream of calorimeter-style energy samples, one per 25 ns crossing, into a coarse trigger energy code. It keeps the eight most recent valid samples. Each sample is multiplied by its own signed fixed-point weight from a small writable weight bank, and the products are added. The total is credited to one reference crossing inside the window: four samples come before it and three after. A negative total is taken as zero. Totals below a programmable low-energy cut are also zeroed. Whatever remains is rounded to coarse output units and capped at the largest code.

A configuration bit selects a five-tap variant. In that mode the taps at the window ends stop contributing. The output strobe rises at a fixed delay after the sample that completes a window. It never rises before eight samples have arrived since reset.

Top module: `trig_fir_sum`

## Requirements
- R1: After reset, out_valid and out_code are 0 and the weight bank holds the Q2.8 values -54,-54,-54,-36,241,51,-44,-54 at indices 0 to 7.
- R2: Weight index k multiplies the sample at crossing offset k-4 from the reference. The reference is the sample that arrived three valid samples before the newest one, so index 7 pairs with the newest sample and index 0 with the oldest.
- R3: out_valid stays low until eight valid samples have been accepted after reset.
- R4: Once the window is full, each accepted sample produces exactly one result. out_valid is high on the third rising clock edge after the edge that accepted that sample, counting that edge as edge 0.
- R5: The weighted sum is the exact sum over enabled taps of weight (signed 11-bit, 8 fraction bits) times sample (unsigned 10-bit). No overflow or truncation occurs.
- R6: A negative weighted sum is treated as zero.
- R7: When the clamped sum, in units of 1/256 sample LSB, is below cfg_thr, the result code is 0.
- R8: The code is floor((S+512)/1024) for a clamped sum S that passes the threshold, so one output unit is four sample LSBs and halves round up. Codes above 255 become 255.
- R9: With cfg_five_tap=1, only indices 1 to 5 (offsets -3 to +1) contribute. The weights at indices 0, 6 and 7 have no effect.
- R10: A write with wr_en=1 stores wr_data at index wr_addr. It applies to every window that completes after the write.
- R11: out_code is 0 whenever out_valid is low.
- R12: A window of eight zero samples gives code 0 for any weights.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Sample strobe |
| in_sample | input | SAMPLE_W | Unsigned energy sample |
| cfg_five_tap | input | 1 | 1 selects the five-tap variant |
| cfg_thr | input | ACC_W-1 | Low-energy cut in 1/256 sample LSB |
| wr_en | input | 1 | Weight write strobe |
| wr_addr | input | 3 | Weight index |
| wr_data | input | WGT_W | Signed Q2.8 weight |
| out_valid | output | 1 | Result strobe |
| out_code | output | OUT_W | Quantized trigger energy |

## Verification
The checker assumes that in_valid and in_sample are meaningful only after the internal reset has been released. It also assumes that the weights, the threshold and the mode bit do not change while results are in flight. The bench drives samples only after that release. Before each configuration change it stops the sample stream and lets the three-stage pipeline drain. With that discipline, the bench's own arithmetic model, evaluated when each sample is sent, matches the values the design uses.

// File: rtl/trig_fir_pkg.sv
package trig_fir_pkg;

  localparam int NTAPS   = 8;
  localparam int REF_POS = 4;

  typedef enum logic {
    TAPS_EIGHT = 1'b0,
    TAPS_FIVE  = 1'b1
  } tap_mode_e;

  // Reset weight per index, Q2.8 (value * 256, rounded)
  function automatic int dflt_weight(int k);
    case (k)
      0, 1, 2, 7: return -54;
      3:          return -36;
      4:          return 241;
      5:          return 51;
      6:          return -44;
      default:    return 0;
    endcase
  endfunction

  // Five-tap variant keeps offsets -3..+1 only
  function automatic logic tap_used(tap_mode_e m, int k);
    if (m == TAPS_EIGHT) return 1'b1;
    return (k >= 1) && (k <= 5);
  endfunction

endpackage

// File: rtl/trig_fir_window.sv
module trig_fir_window #(
  parameter int NTAPS    = 8,
  parameter int SAMPLE_W = 10
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               in_valid,
  input  logic [SAMPLE_W-1:0]                in_sample,
  output logic [NTAPS-1:0][SAMPLE_W-1:0]     win,
  output logic                               win_valid
);

  localparam int CNT_W = $clog2(NTAPS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(NTAPS);

  logic [NTAPS-1:0][SAMPLE_W-1:0] win_q, win_d;
  logic [CNT_W-1:0]               cnt_q, cnt_d;
  logic                           wv_q, wv_d;

  // slot 0 holds the newest sample
  for (genvar i = 0; i < NTAPS; i++) begin : g_shift
    if (i == 0) begin : g_head
      assign win_d[i] = in_valid ? in_sample : win_q[i];
    end else begin : g_body
      assign win_d[i] = in_valid ? win_q[i-1] : win_q[i];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (in_valid && (cnt_q != FULL)) cnt_d = cnt_q + 1'b1;
    wv_d = in_valid && (cnt_q >= FULL - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      cnt_q <= '0;
      wv_q  <= 1'b0;
    end else begin
      win_q <= win_d;
      cnt_q <= cnt_d;
      wv_q  <= wv_d;
    end
  end

  assign win       = win_q;
  assign win_valid = wv_q;

endmodule

// File: rtl/trig_fir_wbank.sv
module trig_fir_wbank
  import trig_fir_pkg::*;
#(
  parameter int NTAPS  = 8,
  parameter int WGT_W  = 11,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          wr_en,
  input  logic [ADDR_W-1:0]             wr_addr,
  input  logic [WGT_W-1:0]              wr_data,
  output logic [NTAPS-1:0][WGT_W-1:0]   weights
);

  for (genvar i = 0; i < NTAPS; i++) begin : g_reg
    localparam int RV = dflt_weight(i);
    logic [WGT_W-1:0] w_q, w_d;
    logic             hit;

    assign hit = wr_en && (wr_addr == ADDR_W'(i));

    always_comb begin
      w_d = w_q;
      if (hit) w_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) w_q <= WGT_W'(RV);
      else        w_q <= w_d;
    end

    assign weights[i] = w_q;
  end

endmodule

// File: rtl/trig_fir_mac.sv
module trig_fir_mac
  import trig_fir_pkg::*;
#(
  parameter int NTAPS    = 8,
  parameter int SAMPLE_W = 10,
  parameter int WGT_W    = 11,
  parameter int ACC_W    = 25
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [NTAPS-1:0][SAMPLE_W-1:0]     win,
  input  logic                               win_valid,
  input  logic [NTAPS-1:0][WGT_W-1:0]        weights,
  input  logic                               five_tap,
  output logic signed [ACC_W-1:0]            acc,
  output logic                               acc_valid
);

  localparam int PROD_W = SAMPLE_W + 1 + WGT_W;
  localparam int EXT_W  = ACC_W - PROD_W;

  tap_mode_e mode;
  assign mode = tap_mode_e'(five_tap);

  logic signed [PROD_W-1:0] prod [NTAPS];

  // weight index k meets window slot NTAPS-1-k (offset k-REF_POS)
  for (genvar k = 0; k < NTAPS; k++) begin : g_tap
    logic signed [SAMPLE_W:0] s_ext;
    logic signed [WGT_W-1:0]  w_s;
    assign s_ext = $signed({1'b0, win[NTAPS-1-k]});
    assign w_s   = $signed(weights[k]);
    assign prod[k] = tap_used(mode, k) ? PROD_W'(s_ext * w_s) : '0;
  end

  logic signed [ACC_W-1:0] acc_d, acc_q;
  logic                    av_q;

  always_comb begin
    acc_d = '0;
    for (int k = 0; k < NTAPS; k++) begin
      acc_d = acc_d + $signed({{EXT_W{prod[k][PROD_W-1]}}, prod[k]});
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      av_q  <= 1'b0;
    end else begin
      av_q <= win_valid;
      if (win_valid) acc_q <= acc_d;
    end
  end

  assign acc       = acc_q;
  assign acc_valid = av_q;

endmodule

// File: rtl/trig_fir_quant.sv
module trig_fir_quant #(
  parameter int ACC_W = 25,
  parameter int SHIFT = 10,
  parameter int OUT_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic signed [ACC_W-1:0]  acc,
  input  logic                     acc_valid,
  input  logic [ACC_W-2:0]         thr,
  output logic                     out_valid,
  output logic [OUT_W-1:0]         out_code
);

  localparam logic [ACC_W-1:0] HALF = ACC_W'(1) << (SHIFT - 1);

  logic [ACC_W-2:0] mag;
  logic             below;
  logic [ACC_W-1:0] rnd, scaled;
  logic             sat;
  logic [OUT_W-1:0] code_d, code_q;
  logic             ov_q;

  always_comb begin
    mag    = acc[ACC_W-1] ? '0 : acc[ACC_W-2:0];
    below  = mag < thr;
    rnd    = {1'b0, mag} + HALF;
    scaled = rnd >> SHIFT;
    sat    = |scaled[ACC_W-1:OUT_W];
    if (!acc_valid || below) code_d = '0;
    else if (sat)            code_d = '1;
    else                     code_d = scaled[OUT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      ov_q   <= 1'b0;
    end else begin
      code_q <= code_d;
      ov_q   <= acc_valid;
    end
  end

  assign out_valid = ov_q;
  assign out_code  = code_q;

endmodule

// File: rtl/trig_fir_sum.sv
module trig_fir_sum
  import trig_fir_pkg::*;
#(
  parameter int SAMPLE_W   = 10,
  parameter int WGT_W      = 11,
  parameter int WGT_FRAC   = 8,
  parameter int UNIT_SHIFT = 2,
  parameter int OUT_W      = 8,
  localparam int ADDR_W    = $clog2(NTAPS),
  localparam int ACC_W     = SAMPLE_W + 1 + WGT_W + $clog2(NTAPS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [SAMPLE_W-1:0]  in_sample,
  input  logic                 cfg_five_tap,
  input  logic [ACC_W-2:0]     cfg_thr,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WGT_W-1:0]     wr_data,
  output logic                 out_valid,
  output logic [OUT_W-1:0]     out_code
);

  localparam int SHIFT = WGT_FRAC + UNIT_SHIFT;

  // reset: asserted at once, released two edges later
  logic rst_meta, rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_core_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_core_n <= rst_meta;
    end
  end

  logic [NTAPS-1:0][SAMPLE_W-1:0] win;
  logic                           win_valid;
  logic [NTAPS-1:0][WGT_W-1:0]    weights;
  logic signed [ACC_W-1:0]        acc;
  logic                           acc_valid;

  trig_fir_window #(.NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W)) u_window (
    .clk(clk), .rst_n(rst_core_n),
    .in_valid(in_valid), .in_sample(in_sample),
    .win(win), .win_valid(win_valid)
  );

  trig_fir_wbank #(.NTAPS(NTAPS), .WGT_W(WGT_W), .ADDR_W(ADDR_W)) u_wbank (
    .clk(clk), .rst_n(rst_core_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .weights(weights)
  );

  trig_fir_mac #(.NTAPS(NTAPS), .SAMPLE_W(SAMPLE_W), .WGT_W(WGT_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_core_n),
    .win(win), .win_valid(win_valid),
    .weights(weights), .five_tap(cfg_five_tap),
    .acc(acc), .acc_valid(acc_valid)
  );

  trig_fir_quant #(.ACC_W(ACC_W), .SHIFT(SHIFT), .OUT_W(OUT_W)) u_quant (
    .clk(clk), .rst_n(rst_core_n),
    .acc(acc), .acc_valid(acc_valid), .thr(cfg_thr),
    .out_valid(out_valid), .out_code(out_code)
  );

endmodule

// File: rtl/trig_fir_sum_chk.sv
module trig_fir_sum_chk #(
  parameter int SAMPLE_W = 10,
  parameter int OUT_W    = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic [SAMPLE_W-1:0] in_sample,
  input logic                out_valid,
  input logic [OUT_W-1:0]    out_code
);

  logic [3:0] fill_cnt, zrun;
  logic [2:0] fp, zp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_cnt <= '0;
      zrun     <= '0;
      fp       <= '0;
      zp       <= '0;
    end else begin
      if (in_valid && fill_cnt < 4'd8) fill_cnt <= fill_cnt + 4'd1;
      if (in_valid) begin
        if (in_sample != '0) zrun <= '0;
        else if (zrun < 4'd8) zrun <= zrun + 4'd1;
      end
      fp <= {fp[1:0], in_valid && (fill_cnt >= 4'd7)};
      zp <= {zp[1:0], in_valid && (in_sample == '0) && (zrun >= 4'd7)};
    end
  end

  p_latency_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == fp[2]);

  p_no_early_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (fill_cnt >= 4'd8));

  p_idle_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> (out_code == '0));

  p_zero_window_r12: assert property (@(posedge clk) disable iff (!rst_n)
    zp[2] |-> (out_valid && out_code == '0));

endmodule

bind trig_fir_sum trig_fir_sum_chk #(.SAMPLE_W(SAMPLE_W), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_core_n),
  .in_valid(in_valid), .in_sample(in_sample),
  .out_valid(out_valid), .out_code(out_code)
);

// File: tb/trig_fir_sum_bench.sv
module trig_fir_sum_bench;

  localparam int SW = 10, WW = 11, OW = 8, AW = 25;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic [SW-1:0] in_sample;
  logic          cfg_five_tap;
  logic [AW-2:0] cfg_thr;
  logic          wr_en;
  logic [2:0]    wr_addr;
  logic [WW-1:0] wr_data;
  logic          out_valid;
  logic [OW-1:0] out_code;

  always #5 clk = ~clk;

  trig_fir_sum u_trig_fir_sum (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .cfg_five_tap(cfg_five_tap), .cfg_thr(cfg_thr),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .out_valid(out_valid), .out_code(out_code)
  );

  int checks = 0, errors = 0;
  int hist[8];
  int wmod[8];
  int nsamp = 0, thr_m = 0, five_m = 0;
  int expq[64];
  int wr_p = 0, rd_p = 0;
  bit run = 0;
  string tag = "R5";
  int lfsr = 16'hACE1;

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int model();
    int acc = 0;
    int q;
    for (int k = 0; k < 8; k++)
      if (five_m == 0 || (k >= 1 && k <= 5)) acc += wmod[k] * hist[7-k];
    if (acc < 0) acc = 0;
    if (acc < thr_m) return 0;
    q = (acc + 512) / 1024;
    if (q > 255) q = 255;
    return q;
  endfunction

  function automatic int nxt(int v);
    int b = ((v >> 0) ^ (v >> 2) ^ (v >> 3) ^ (v >> 5)) & 1;
    return ((v >> 1) | (b << 15)) & 16'hFFFF;
  endfunction

  task automatic send(int s);
    @(negedge clk);
    in_valid  = 1'b1;
    in_sample = SW'(s);
    for (int i = 7; i > 0; i--) hist[i] = hist[i-1];
    hist[0] = s;
    nsamp++;
    if (nsamp >= 8) begin
      expq[wr_p % 64] = model();
      wr_p++;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  task automatic drain();
    idle(6);
    chk(rd_p == wr_p, "R4 result count", rd_p, wr_p);
  endtask

  task automatic wr_w(int k, int v);
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_addr = 3'(k); wr_data = WW'(v);
    @(negedge clk);
    wr_en = 1'b0;
    wmod[k] = v;
  endtask

  // result monitor, away from the active edge
  always @(negedge clk) begin
    if (run) begin
      if (out_valid) begin
        if (rd_p == wr_p) chk(1'b0, "R3/R4 unexpected result", out_code, -1);
        else begin
          chk(out_code == OW'(expq[rd_p % 64]), tag, out_code, expq[rd_p % 64]);
          rd_p++;
        end
      end else if (out_code != '0) begin
        chk(1'b0, "R11 code while idle", out_code, 0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    bit v1, v2, v3;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0; cfg_five_tap = 1'b0;
    cfg_thr = '0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    for (int i = 0; i < 8; i++) hist[i] = 0;
    wmod = '{-54, -54, -54, -36, 241, 51, -44, -54};
    repeat (3) @(negedge clk);
    chk(out_valid == 1'b0, "R1 out_valid reset", out_valid, 0);
    chk(out_code == '0, "R1 out_code reset", out_code, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    run = 1;

    // R3: seven samples give nothing
    tag = "R1/R2 default weights";
    for (int i = 0; i < 7; i++) send(100 * i + 50);
    idle(6);
    chk(rd_p == 0 && wr_p == 0, "R3 no result before fill", rd_p, 0);

    // R4: eighth sample, result on third edge
    send(800);
    @(negedge clk); in_valid = 1'b0; v1 = out_valid;
    @(negedge clk); v2 = out_valid;
    @(negedge clk); v3 = out_valid;
    chk({v1, v2, v3} == 3'b001, "R4 latency pattern", {v1, v2, v3}, 1);
    drain();
    chk(out_code == '0, "R11 idle code", out_code, 0);

    // R1/R2/R5/R6: impulse sweep through default taps
    tag = "R2/R5/R6 impulse";
    for (int a = 0; a < 1024; a += 7) begin
      send(a);
      for (int z = 0; z < 8; z++) send(0);
    end
    drain();

    // R7: threshold on a random stream with gaps
    tag = "R7 threshold";
    cfg_thr = AW'(60 * 256); thr_m = 60 * 256;
    for (int i = 0; i < 1500; i++) begin
      lfsr = nxt(lfsr);
      send(lfsr & 1023);
      if ((lfsr & 15) == 3) idle(2);
    end
    drain();
    cfg_thr = '0; thr_m = 0;

    // R8/R10: unit weight on reference only, exhaustive rounding
    tag = "R8/R10 rounding";
    for (int k = 0; k < 8; k++) wr_w(k, (k == 4) ? 256 : 0);
    for (int a = 0; a < 1024; a++) send(a);
    drain();
    tag = "R8 saturation";
    wr_w(4, 1023);
    for (int a = 0; a < 1024; a += 3) send(a);
    drain();

    // R9: five-tap mode, outer weights large and ignored
    tag = "R9 five-tap";
    cfg_five_tap = 1'b1; five_m = 1;
    wr_w(0, 900); wr_w(1, -384); wr_w(2, -384); wr_w(3, 256);
    wr_w(4, 256); wr_w(5, 256); wr_w(6, 700); wr_w(7, -900);
    for (int i = 0; i < 1500; i++) begin
      lfsr = nxt(lfsr);
      send(lfsr & 1023);
    end
    drain();
    tag = "R9 outer impulse";
    for (int a = 1; a < 1024; a += 64) begin
      send(a);
      for (int z = 0; z < 8; z++) send(0);
    end
    drain();

    // R12: zero window, positive weights, eight-tap
    tag = "R12 zero window";
    cfg_five_tap = 1'b0; five_m = 0;
    for (int k = 0; k < 8; k++) wr_w(k, 200 + k);
    for (int i = 0; i < 20; i++) send(0);
    drain();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule